// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Unit

This unit sits next to a small CPU core. It decides at each instruction boundary whether a pending interrupt is taken. The requests are evaluated on every clock. A decision counts only in a cycle where the core signals that the current instruction has completed. There are three sources: a non-maskable request, a software exception carrying a 2-bit exception number, and a maskable request that brings its own level and vector number. The unit holds the processor status word, which contains an interrupt-enable flag and a current-level field. It also holds the stack pointer and a programmable vector table base.

When a request wins, a fixed state sequence runs:
- IDLE goes to SAVE_SR, which pushes the status word.
- SAVE_SR goes to SAVE_PC, which pushes the captured program counter.
- SAVE_PC goes to UPDATE, which clears the enable flag and, for maskable requests only, loads the accepted level.
- UPDATE goes to FETCH, which loads the vector address into the core's program counter and acknowledges the source.
- FETCH returns to IDLE.

A return strobe at a boundary runs a second sequence:
- IDLE goes to POP_PC, which reloads the program counter from the stack.
- POP_PC goes to POP_SR, which restores the status word.
- POP_SR returns to IDLE.

Software may rewrite the enable flag and level while the unit is idle. This is how nested interrupts of strictly higher level are allowed.

Top module: `irq_accept_top`

## Requirements
- R1: After reset the status word reads 0 (enable clear, level 0), the stack pointer reads 0x100, the vector base is 0, busy is low, and no stack, load or acknowledge strobe is active.
- R2: A sequence starts only on a clock edge where `insn_done_i` is high. Requests held while `insn_done_i` is low cause no activity.
- R3: Entry pushes the old status word to address SP-4 and then the captured PC to SP-8, leaving SP lowered by 8. The PC load happens in the fourth cycle after the accepting edge.
- R4: A maskable request is accepted only when enable (status bit 0) is 1 and its level is strictly greater than the level field (status bits 7:4). It then jumps to base + 4*vector, clears enable and sets the level field to the request's level.
- R5: A maskable request that fails the R4 test is ignored. There is no stack write, and the status word and SP are unchanged.
- R6: A non-maskable request is accepted whatever the enable flag. It uses vector 7 (address base + 28), clears enable and leaves the level field unchanged.
- R7: Priority at a boundary is non-maskable first, then software exception, then maskable. Only the winner is acknowledged, and the losers stay pending.
- R8: A software exception with number n (0..3) is accepted whatever the enable flag. It uses vector 12+n, clears enable and leaves the level field unchanged.
- R9: A return strobe at a boundary pops the PC from SP and loads it, then restores the status word from SP+4. SP rises by 8, and the restored word equals the one saved at entry.
- R10: The vector base is software-writable, and the fetch address is a 32-bit add that wraps modulo 2^32.
- R11: A status write while idle sets the enable flag and level. After re-enabling inside a handler, only a strictly higher level nests.
- R12: Exactly one acknowledge strobe is raised per entry, in the same cycle as the vector PC load, and never more than one at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 32 | Current PC, captured at acceptance |
| mi_req_i | input | 1 | Maskable request |
| mi_level_i | input | 4 | Level of maskable request |
| mi_vec_i | input | 8 | Vector number of maskable request |
| nmi_req_i | input | 1 | Non-maskable request |
| swx_req_i | input | 1 | Software exception request |
| swx_num_i | input | 2 | Software exception number |
| reti_i | input | 1 | Return-from-interrupt strobe |
| sr_wr_i | input | 1 | Status write strobe |
| sr_wr_ie_i | input | 1 | Enable value for status write |
| sr_wr_level_i | input | 4 | Level value for status write |
| vbase_wr_i | input | 1 | Vector base write strobe |
| vbase_wr_data_i | input | 32 | New vector base |
| stk_rdata_i | input | 32 | Stack read data, valid in the same cycle |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | 32 | Stack address |
| stk_wdata_o | output | 32 | Stack write data |
| pc_load_o | output | 1 | PC load strobe |
| pc_val_o | output | 32 | Value to load into PC |
| ack_nmi_o | output | 1 | Non-maskable request taken |
| ack_swx_o | output | 1 | Software exception taken |
| ack_mi_o | output | 1 | Maskable request taken |
| busy_o | output | 1 | A sequence is in progress |
| status_o | output | 32 | Status word (bit 0 enable, bits 7:4 level) |
| sp_o | output | 32 | Stack pointer |

## Verification
The assertions assume the following about the inputs:
- A requester holds its request until it sees its acknowledge.
- Return strobes arrive only when something has been pushed.
- Status writes are not issued in the same cycle as an instruction boundary.
- Stack read data is valid combinationally in the cycle of the read.

The stimulus keeps within these assumptions in several ways. It tracks nesting depth and issues returns only at non-zero depth, forcing one when the depth cap is reached. It drives status and base writes with the boundary strobe low. It serves reads from a bench memory indexed by the stack address.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_SR,
        ST_SAVE_PC,
        ST_UPDATE,
        ST_FETCH,
        ST_POP_PC,
        ST_POP_SR
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_SWX,
        SRC_MASK
    } irq_src_e;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int LVL_W        = 4,
    parameter int VEC_W        = 8,
    parameter int SWX_W        = 2,
    parameter int NMI_VEC      = 7,
    parameter int SWX_VEC_BASE = 12
) (
    input  logic             nmi_req,
    input  logic             swx_req,
    input  logic [SWX_W-1:0] swx_num,
    input  logic             mi_req,
    input  logic [LVL_W-1:0] mi_level,
    input  logic [VEC_W-1:0] mi_vec,
    input  logic             ie,
    input  logic [LVL_W-1:0] cur_level,
    output irq_src_e         win_src,
    output logic [VEC_W-1:0] win_vec,
    output logic [LVL_W-1:0] win_level
);

    logic mi_ok;
    assign mi_ok = mi_req && ie && (mi_level > cur_level);

    always_comb begin
        win_src   = SRC_NONE;
        win_vec   = '0;
        win_level = cur_level;
        if (nmi_req) begin
            win_src = SRC_NMI;
            win_vec = VEC_W'(NMI_VEC);
        end else if (swx_req) begin
            win_src = SRC_SWX;
            win_vec = VEC_W'(SWX_VEC_BASE) + VEC_W'(swx_num);
        end else if (mi_ok) begin
            win_src   = SRC_MASK;
            win_vec   = mi_vec;
            win_level = mi_level;
        end
    end

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);

    localparam int OFF_W = VEC_W + 2;

    logic [OFF_W-1:0] byte_off;
    assign byte_off = {vec, 2'b00};

    generate
        if (OFF_W < ADDR_W) begin : g_ext
            assign addr = base + {{(ADDR_W-OFF_W){1'b0}}, byte_off};
        end else begin : g_trunc
            assign addr = base + byte_off[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/irq_stack_ptr.sv
module irq_stack_ptr #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] RESET_VAL = 32'h100,
    parameter int          STEP      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    input  logic              inc,
    output logic [ADDR_W-1:0] sp
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= ADDR_W'(RESET_VAL);
        end else if (dec) begin
            sp <= sp - STEP_V;
        end else if (inc) begin
            sp <= sp + STEP_V;
        end
    end

endmodule

// File: rtl/irq_accept_top.sv
module irq_accept_top
    import irq_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          LVL_W        = 4,
    parameter int          VEC_W        = 8,
    parameter int          SWX_W        = 2,
    parameter int          NMI_VEC      = 7,
    parameter int          SWX_VEC_BASE = 12,
    parameter int          LVL_LSB      = 4,
    parameter logic [31:0] SP_RESET     = 32'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              mi_req_i,
    input  logic [LVL_W-1:0]  mi_level_i,
    input  logic [VEC_W-1:0]  mi_vec_i,
    input  logic              nmi_req_i,
    input  logic              swx_req_i,
    input  logic [SWX_W-1:0]  swx_num_i,
    input  logic              reti_i,
    input  logic              sr_wr_i,
    input  logic              sr_wr_ie_i,
    input  logic [LVL_W-1:0]  sr_wr_level_i,
    input  logic              vbase_wr_i,
    input  logic [ADDR_W-1:0] vbase_wr_data_i,
    input  logic [ADDR_W-1:0] stk_rdata_i,
    output logic              stk_we_o,
    output logic              stk_re_o,
    output logic [ADDR_W-1:0] stk_addr_o,
    output logic [ADDR_W-1:0] stk_wdata_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_val_o,
    output logic              ack_nmi_o,
    output logic              ack_swx_o,
    output logic              ack_mi_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] status_o,
    output logic [ADDR_W-1:0] sp_o
);

    localparam int                WORD_BYTES = 4;
    localparam logic [ADDR_W-1:0] WORD_V     = ADDR_W'(WORD_BYTES);

    seq_state_e state_q, state_d;

    irq_src_e          src_q;
    logic [VEC_W-1:0]  vec_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [ADDR_W-1:0] pc_q;
    logic              ie_q;
    logic [LVL_W-1:0]  il_q;
    logic [ADDR_W-1:0] vbase_q;

    irq_src_e          win_src;
    logic [VEC_W-1:0]  win_vec;
    logic [LVL_W-1:0]  win_level;
    logic [ADDR_W-1:0] fetch_addr;
    logic [ADDR_W-1:0] sp;
    logic              sp_dec;
    logic              sp_inc;
    logic              start_ret;
    logic              start_irq;
    logic [ADDR_W-1:0] sr_word;

    irq_arbiter #(
        .LVL_W        (LVL_W),
        .VEC_W        (VEC_W),
        .SWX_W        (SWX_W),
        .NMI_VEC      (NMI_VEC),
        .SWX_VEC_BASE (SWX_VEC_BASE)
    ) u_arb (
        .nmi_req   (nmi_req_i),
        .swx_req   (swx_req_i),
        .swx_num   (swx_num_i),
        .mi_req    (mi_req_i),
        .mi_level  (mi_level_i),
        .mi_vec    (mi_vec_i),
        .ie        (ie_q),
        .cur_level (il_q),
        .win_src   (win_src),
        .win_vec   (win_vec),
        .win_level (win_level)
    );

    irq_vec_addr #(
        .ADDR_W (ADDR_W),
        .VEC_W  (VEC_W)
    ) u_vaddr (
        .base (vbase_q),
        .vec  (vec_q),
        .addr (fetch_addr)
    );

    irq_stack_ptr #(
        .ADDR_W    (ADDR_W),
        .RESET_VAL (SP_RESET),
        .STEP      (WORD_BYTES)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (sp_dec),
        .inc   (sp_inc),
        .sp    (sp)
    );

    always_comb begin
        sr_word                     = '0;
        sr_word[0]                  = ie_q;
        sr_word[LVL_LSB +: LVL_W]   = il_q;
    end

    assign start_ret = (state_q == ST_IDLE) && insn_done_i && reti_i;
    assign start_irq = (state_q == ST_IDLE) && insn_done_i && !reti_i
                       && (win_src != SRC_NONE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ret) begin
                    state_d = ST_POP_PC;
                end else if (start_irq) begin
                    state_d = ST_SAVE_SR;
                end
            end
            ST_SAVE_SR: state_d = ST_SAVE_PC;
            ST_SAVE_PC: state_d = ST_UPDATE;
            ST_UPDATE:  state_d = ST_FETCH;
            ST_FETCH:   state_d = ST_IDLE;
            ST_POP_PC:  state_d = ST_POP_SR;
            ST_POP_SR:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Status, capture and base registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= SRC_NONE;
            vec_q   <= '0;
            lvl_q   <= '0;
            pc_q    <= '0;
            ie_q    <= 1'b0;
            il_q    <= '0;
            vbase_q <= '0;
        end else begin
            if (vbase_wr_i) begin
                vbase_q <= vbase_wr_data_i;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_irq) begin
                        src_q <= win_src;
                        vec_q <= win_vec;
                        lvl_q <= win_level;
                        pc_q  <= pc_i;
                    end else if (sr_wr_i && !start_ret) begin
                        ie_q <= sr_wr_ie_i;
                        il_q <= sr_wr_level_i;
                    end
                end
                ST_UPDATE: begin
                    ie_q <= 1'b0;
                    if (src_q == SRC_MASK) begin
                        il_q <= lvl_q;
                    end
                end
                ST_POP_SR: begin
                    ie_q <= stk_rdata_i[0];
                    il_q <= stk_rdata_i[LVL_LSB +: LVL_W];
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        stk_we_o    = 1'b0;
        stk_re_o    = 1'b0;
        stk_addr_o  = sp;
        stk_wdata_o = '0;
        pc_load_o   = 1'b0;
        pc_val_o    = '0;
        ack_nmi_o   = 1'b0;
        ack_swx_o   = 1'b0;
        ack_mi_o    = 1'b0;
        sp_dec      = 1'b0;
        sp_inc      = 1'b0;
        unique case (state_q)
            ST_SAVE_SR: begin
                stk_we_o    = 1'b1;
                stk_addr_o  = sp - WORD_V;
                stk_wdata_o = sr_word;
                sp_dec      = 1'b1;
            end
            ST_SAVE_PC: begin
                stk_we_o    = 1'b1;
                stk_addr_o  = sp - WORD_V;
                stk_wdata_o = pc_q;
                sp_dec      = 1'b1;
            end
            ST_FETCH: begin
                pc_load_o = 1'b1;
                pc_val_o  = fetch_addr;
                ack_nmi_o = (src_q == SRC_NMI);
                ack_swx_o = (src_q == SRC_SWX);
                ack_mi_o  = (src_q == SRC_MASK);
            end
            ST_POP_PC: begin
                stk_re_o  = 1'b1;
                pc_load_o = 1'b1;
                pc_val_o  = stk_rdata_i;
                sp_inc    = 1'b1;
            end
            ST_POP_SR: begin
                stk_re_o = 1'b1;
                sp_inc   = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign status_o = sr_word;
    assign sp_o     = sp;

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int ADDR_W  = 32,
    parameter int LVL_W   = 4,
    parameter int LVL_LSB = 4,
    parameter int NMI_VEC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_done_i,
    input logic              busy_o,
    input logic              stk_we_o,
    input logic              stk_re_o,
    input logic              pc_load_o,
    input logic [ADDR_W-1:0] pc_val_o,
    input logic              ack_nmi_o,
    input logic              ack_swx_o,
    input logic              ack_mi_o,
    input logic [ADDR_W-1:0] status_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic [ADDR_W-1:0] vbase
);

    // R2: a sequence begins only after a boundary cycle
    a_r2_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(insn_done_i));

    // R3: each stack write lowers the pointer by one word
    a_r3_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we_o |=> (sp_o == $past(sp_o) - ADDR_W'(4)));

    // R9: each stack read raises the pointer by one word
    a_r9_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        stk_re_o |=> (sp_o == $past(sp_o) + ADDR_W'(4)));

    // R12: at most one acknowledge at a time
    a_r12_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_nmi_o, ack_swx_o, ack_mi_o}));

    // R12: acknowledge coincides with a PC load
    a_r12_ack_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_nmi_o || ack_swx_o || ack_mi_o) |-> pc_load_o);

    // R4: enable flag reads clear when an entry is acknowledged
    a_r4_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_nmi_o || ack_swx_o || ack_mi_o) |-> (status_o[0] == 1'b0));

    // R6: non-maskable entry goes to base + 4*7 and keeps the level
    a_r6_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi_o |-> (pc_val_o == vbase + ADDR_W'(NMI_VEC * 4)));

    a_r6_nmi_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi_o |-> (status_o[LVL_LSB +: LVL_W] == $past(status_o[LVL_LSB +: LVL_W], 4)));

endmodule

bind irq_accept_top irq_accept_chk #(
    .ADDR_W  (ADDR_W),
    .LVL_W   (LVL_W),
    .LVL_LSB (LVL_LSB),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_done_i (insn_done_i),
    .busy_o      (busy_o),
    .stk_we_o    (stk_we_o),
    .stk_re_o    (stk_re_o),
    .pc_load_o   (pc_load_o),
    .pc_val_o    (pc_val_o),
    .ack_nmi_o   (ack_nmi_o),
    .ack_swx_o   (ack_swx_o),
    .ack_mi_o    (ack_mi_o),
    .status_o    (status_o),
    .sp_o        (sp_o),
    .vbase       (vbase_q)
);

// File: tb/irq_accept_tb.sv
module irq_accept_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        mi_req_i = 1'b0;
    logic [3:0]  mi_level_i = '0;
    logic [7:0]  mi_vec_i = '0;
    logic        nmi_req_i = 1'b0;
    logic        swx_req_i = 1'b0;
    logic [1:0]  swx_num_i = '0;
    logic        reti_i = 1'b0;
    logic        sr_wr_i = 1'b0;
    logic        sr_wr_ie_i = 1'b0;
    logic [3:0]  sr_wr_level_i = '0;
    logic        vbase_wr_i = 1'b0;
    logic [31:0] vbase_wr_data_i = '0;
    logic [31:0] stk_rdata_i;
    logic        stk_we_o, stk_re_o, pc_load_o;
    logic [31:0] stk_addr_o, stk_wdata_o, pc_val_o, status_o, sp_o;
    logic        ack_nmi_o, ack_swx_o, ack_mi_o, busy_o;

    logic [31:0] mem [64];

    int checks = 0;
    int errors = 0;

    // model state
    bit          m_ie = 1'b0;
    logic [3:0]  m_il = '0;
    logic [31:0] m_sp = 32'h100;
    logic [31:0] m_vbase = '0;
    logic [31:0] m_sr_stk [16];
    logic [31:0] m_pc_stk [16];
    int          depth = 0;

    always #2 clk = ~clk;

    irq_accept_top dut_i (
        .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done_i), .pc_i(pc_i),
        .mi_req_i(mi_req_i), .mi_level_i(mi_level_i), .mi_vec_i(mi_vec_i),
        .nmi_req_i(nmi_req_i), .swx_req_i(swx_req_i), .swx_num_i(swx_num_i),
        .reti_i(reti_i), .sr_wr_i(sr_wr_i), .sr_wr_ie_i(sr_wr_ie_i),
        .sr_wr_level_i(sr_wr_level_i), .vbase_wr_i(vbase_wr_i),
        .vbase_wr_data_i(vbase_wr_data_i), .stk_rdata_i(stk_rdata_i),
        .stk_we_o(stk_we_o), .stk_re_o(stk_re_o), .stk_addr_o(stk_addr_o),
        .stk_wdata_o(stk_wdata_o), .pc_load_o(pc_load_o), .pc_val_o(pc_val_o),
        .ack_nmi_o(ack_nmi_o), .ack_swx_o(ack_swx_o), .ack_mi_o(ack_mi_o),
        .busy_o(busy_o), .status_o(status_o), .sp_o(sp_o)
    );

    always @(posedge clk) begin
        if (stk_we_o) mem[stk_addr_o[7:2]] <= stk_wdata_o;
    end
    assign stk_rdata_i = mem[stk_addr_o[7:2]];

    function automatic logic [31:0] sr_word(input bit ie, input logic [3:0] il);
        return {24'd0, il, 3'b000, ie};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic set_sr(input bit ie, input logic [3:0] il);
        @(negedge clk);
        sr_wr_i = 1'b1; sr_wr_ie_i = ie; sr_wr_level_i = il;
        @(negedge clk);
        sr_wr_i = 1'b0;
        m_ie = ie; m_il = il;
        chk(status_o == sr_word(ie, il), "R11 status write", status_o, sr_word(ie, il));
    endtask

    task automatic set_vbase(input logic [31:0] b);
        @(negedge clk);
        vbase_wr_i = 1'b1; vbase_wr_data_i = b;
        @(negedge clk);
        vbase_wr_i = 1'b0;
        m_vbase = b;
    endtask

    // one boundary with the given requests; compares all effects with the model
    task automatic do_entry(input bit nmi, input bit swx, input logic [1:0] swxn,
                            input bit mi, input logic [3:0] lvl, input logic [7:0] vec,
                            input logic [31:0] pc);
        int          win;      // 0 none, 1 nmi, 2 swx, 3 maskable
        logic [7:0]  evec;
        logic [31:0] old_sr, old_sp, exp_pc, got_pc;
        int          load_k, acks;
        bit          a_n, a_s, a_m, busy_seen;
        string       tg;
        old_sr = sr_word(m_ie, m_il);
        old_sp = m_sp;
        win = 0; evec = '0;
        if (nmi) begin win = 1; evec = 8'd7; end
        else if (swx) begin win = 2; evec = 8'd12 + {6'd0, swxn}; end
        else if (mi && m_ie && (lvl > m_il)) begin win = 3; evec = vec; end
        tg = (win == 1) ? "R6" : (win == 2) ? "R8" : (win == 3) ? "R4" : "R5";
        exp_pc = m_vbase + {22'd0, evec, 2'b00};

        @(negedge clk);
        nmi_req_i = nmi; swx_req_i = swx; swx_num_i = swxn;
        mi_req_i = mi; mi_level_i = lvl; mi_vec_i = vec; pc_i = pc;
        insn_done_i = 1'b1;
        load_k = 0; acks = 0; a_n = 0; a_s = 0; a_m = 0; busy_seen = 0; got_pc = '0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 1) insn_done_i = 1'b0;
            if (busy_o) busy_seen = 1;
            if (pc_load_o && load_k == 0) begin load_k = k; got_pc = pc_val_o; end
            if (ack_nmi_o) begin a_n = 1; acks++; end
            if (ack_swx_o) begin a_s = 1; acks++; end
            if (ack_mi_o)  begin a_m = 1; acks++; end
        end
        nmi_req_i = 0; swx_req_i = 0; mi_req_i = 0;

        if (win == 0) begin
            chk(!busy_seen && load_k == 0, "R5 no activity", {31'd0, busy_seen}, 0);
            chk(status_o == old_sr, "R5 status kept", status_o, old_sr);
            chk(sp_o == old_sp, "R5 sp kept", sp_o, old_sp);
        end else begin
            chk(load_k == 4, "R3 load timing", load_k, 4);
            chk(got_pc == exp_pc, {tg, " R10 vector address"}, got_pc, exp_pc);
            chk(acks == 1, "R12 single ack", acks, 1);
            chk(a_n == (win == 1) && a_s == (win == 2) && a_m == (win == 3),
                "R7 ack source", {29'd0, a_n, a_s, a_m},
                (win == 1) ? 4 : (win == 2) ? 2 : 1);
            if (win == 3) m_il = lvl;
            m_ie = 1'b0;
            m_sp = old_sp - 32'd8;
            chk(status_o == sr_word(m_ie, m_il), {tg, " status after entry"},
                status_o, sr_word(m_ie, m_il));
            chk(sp_o == m_sp, "R3 sp after push", sp_o, m_sp);
            chk(mem[(old_sp - 32'd4) >> 2 & 32'h3f] == old_sr, "R3 pushed status",
                mem[(old_sp - 32'd4) >> 2 & 32'h3f], old_sr);
            chk(mem[(old_sp - 32'd8) >> 2 & 32'h3f] == pc, "R3 pushed pc",
                mem[(old_sp - 32'd8) >> 2 & 32'h3f], pc);
            m_sr_stk[depth] = old_sr;
            m_pc_stk[depth] = pc;
            depth++;
        end
    endtask

    task automatic do_return();
        logic [31:0] esr, epc;
        depth--;
        esr = m_sr_stk[depth];
        epc = m_pc_stk[depth];
        @(negedge clk);
        reti_i = 1'b1; insn_done_i = 1'b1;
        @(negedge clk);
        reti_i = 1'b0; insn_done_i = 1'b0;
        chk(pc_load_o && pc_val_o == epc, "R9 pc popped", pc_val_o, epc);
        @(negedge clk);
        @(negedge clk);
        m_sp = m_sp + 32'd8;
        m_ie = esr[0]; m_il = esr[7:4];
        chk(status_o == esr, "R9 status restored", status_o, esr);
        chk(sp_o == m_sp && !busy_o, "R9 sp after pop", sp_o, m_sp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit hold_busy;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status_o == 32'd0, "R1 status", status_o, 0);
        chk(sp_o == 32'h100, "R1 sp", sp_o, 32'h100);
        chk(!busy_o && !stk_we_o && !stk_re_o && !pc_load_o
            && !ack_nmi_o && !ack_swx_o && !ack_mi_o, "R1 strobes", {31'd0, busy_o}, 0);

        // R5 enable clear: maskable ignored
        do_entry(0, 0, 0, 1, 4'd9, 8'h20, 32'h1000);
        set_sr(1'b1, 4'd0);

        // R2: held request without boundary does nothing
        @(negedge clk);
        mi_req_i = 1; mi_level_i = 4'd3; mi_vec_i = 8'h20;
        hold_busy = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (busy_o || pc_load_o) hold_busy = 1;
        end
        mi_req_i = 0;
        chk(!hold_busy && sp_o == m_sp, "R2 no boundary no entry", {31'd0, hold_busy}, 0);

        do_entry(0, 0, 0, 1, 4'd3, 8'h20, 32'h2000);   // R4 taken
        do_entry(0, 0, 0, 1, 4'd5, 8'h21, 32'h2004);   // R5 enable now clear
        set_sr(1'b1, 4'd3);
        do_entry(0, 0, 0, 1, 4'd3, 8'h22, 32'h2008);   // R11 equal level ignored
        do_entry(0, 0, 0, 1, 4'd4, 8'h23, 32'h200c);   // R11 higher nests
        do_entry(1, 0, 0, 0, 4'd0, 8'h00, 32'h3000);   // R6 with enable clear
        do_entry(1, 1, 2'd1, 1, 4'd15, 8'h40, 32'h3004); // R7 nmi wins
        do_entry(0, 1, 2'd2, 1, 4'd15, 8'h41, 32'h3008); // R8 / R7 swx over mi
        while (depth > 0) do_return();

        set_vbase(32'hFFFF_FFF0);                      // R10 wrap
        do_entry(1, 0, 0, 0, 4'd0, 8'h00, 32'h4000);
        do_entry(0, 1, 2'd3, 0, 4'd0, 8'h00, 32'h4004);
        while (depth > 0) do_return();

        for (int it = 0; it < 400; it++) begin
            int r;
            r = $urandom % 10;
            if (depth >= 12 || ((r == 3 || r == 4) && depth > 0)) begin
                do_return();
            end else if (r == 0) begin
                set_vbase($urandom);
            end else if (r == 1 || r == 2) begin
                set_sr(1'($urandom), 4'($urandom));
            end else begin
                do_entry(($urandom % 5) == 0, ($urandom % 5) == 0, 2'($urandom),
                         ($urandom % 10) < 7, 4'($urandom), 8'($urandom), $urandom);
            end
        end
        while (depth > 0) do_return();
        report();
    end

endmodule